// File: doc/BRIEF.md
# Selectable-Operand Arithmetic Unit

This block is a small combinational arithmetic unit. One operand enters a ripple chain of full adders unchanged. The other adder input comes from a per-bit four-way selector. A shared two-bit code chooses that input from three sources: the second operand, its bitwise inverse, or a constant of all zeros or all ones. The carry input goes into the least significant stage.

From these two controls, one adder carries out the whole family of arithmetic micro-operations: add, add with carry, subtract, subtract with borrow, plain transfer, increment and decrement. The unit has no clock and no storage. A datapath places it between registers and reads the result and the carry out in the same cycle it applies the operands.

Top module: `mxau_top`

## Requirements
- R1: The result `d_o` equals `a_i + Y + cin_i` modulo 2^WIDTH, where Y is the selected second operand. `cout_o` is bit WIDTH of that unsigned sum. `a_i` reaches the adder with no gating.
- R2: With `sel_i` = 2'b00, Y is `b_i`. The unit gives A+B when `cin_i`=0 and A+B+1 when `cin_i`=1.
- R3: With `sel_i` = 2'b01, Y is the bitwise inverse of `b_i`. The unit gives A+~B when `cin_i`=0 and A-B when `cin_i`=1. In the A-B case, `cout_o` is 1 exactly when A >= B (unsigned).
- R4: With `sel_i` = 2'b10, Y is all zeros. The unit passes A through with `cout_o`=0 when `cin_i`=0, and gives A+1 when `cin_i`=1. Incrementing 4'b1111 gives 4'b0000 with `cout_o`=1.
- R5: With `sel_i` = 2'b11, Y is all ones. With `cin_i`=0 the unit gives A-1, and `cout_o`=1 exactly when A is nonzero. With `cin_i`=1 it passes A through with `cout_o`=1.
- R6: The carry enters at bit 0 and ripples through every stage to `cout_o`. For example, A=4'b1111, B=4'b0000, `sel_i`=2'b00, `cin_i`=1 gives `d_o`=4'b0000 and `cout_o`=1.
- R7: The unit is purely combinational. Its outputs follow any input change without a clock edge, and a later input change replaces the earlier result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH (4) | First operand, fed directly to the adder chain |
| b_i | input | WIDTH (4) | Second operand, a source for the operand selector |
| sel_i | input | 2 | Operand select: 00 B, 01 ~B, 10 zeros, 11 ones |
| cin_i | input | 1 | Carry into the least significant stage |
| d_o | output | WIDTH (4) | Arithmetic result |
| cout_o | output | 1 | Carry out of the most significant stage |

## Verification
The bench sweeps every select code and carry value across all 256 pairs of A and B. This sweep separates the four operand sources from one another and shows the carry input acting as the +1 of each operation. Seeded random vectors re-apply those codes in an unordered sequence, which exposes any dependence on the previous input. Directed corner cases cover the points where a fault hides: increment from all ones, decrement from zero, and subtract with equal operands and with A just below B. They also include a full-length carry ripple, which separates a correct chain from one that drops a carry between stages.

// File: rtl/mxau_pkg.sv
// Package: shared select encoding for the selectable-operand arithmetic unit.
// Assumes: the select code is two bits wide and its values are fixed by datapath convention.
package mxau_pkg;
    typedef enum logic [1:0] {
        OPND_B    = 2'b00,
        OPND_BINV = 2'b01,
        OPND_ZERO = 2'b10,
        OPND_ONES = 2'b11
    } opnd_sel_e;
endpackage

// File: rtl/mxau_operand_mux.sv
// Module: per-bit four-way selector that forms the second adder operand.
// Assumes: one select code is shared by every bit; data inputs 2 and 3 are constant 0 and 1.
module mxau_operand_mux
    import mxau_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] opnd_b,
    input  opnd_sel_e        sel,
    output logic [WIDTH-1:0] y
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [3:0] src;
        // Gather the four candidate sources for this bit position.
        always_comb begin
            src[0] = opnd_b[i];
            src[1] = ~opnd_b[i];
            src[2] = 1'b0;
            src[3] = 1'b1;
        end
        // Route the selected source to this bit of the adder's second input.
        always_comb y[i] = src[sel];
    end
endmodule

// File: rtl/mxau_full_adder.sv
// Module: single-bit full adder cell.
// Assumes: nothing beyond 1-bit inputs; purely combinational.
module mxau_full_adder (
    input  logic x,
    input  logic y,
    input  logic ci,
    output logic s,
    output logic co
);
    logic p;
    // Form the propagate term, sum and carry of one bit.
    always_comb begin
        p  = x ^ y;
        s  = p ^ ci;
        co = (x & y) | (ci & p);
    end
endmodule

// File: rtl/mxau_ripple_chain.sv
// Module: ripple-carry chain of full adder cells, least significant stage first.
// Assumes: the carry input enters stage 0; the final stage's carry is the chain's carry out.
module mxau_ripple_chain #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    logic [WIDTH:0] carry;

    // Seed the chain with the external carry.
    always_comb carry[0] = cin;

    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        mxau_full_adder u_fa (
            .x  (x[i]),
            .y  (y[i]),
            .ci (carry[i]),
            .s  (sum[i]),
            .co (carry[i+1])
        );
    end

    // Take the last stage's carry as the chain output.
    always_comb cout = carry[WIDTH];

    // Compare the gate-level chain with an arithmetic sum (R1, R6).
    always_comb begin
        if (!$isunknown({x, y, cin})) begin
            assert_chain_sum_R1: assert ({cout, sum} == ({1'b0, x} + {1'b0, y} + {{WIDTH{1'b0}}, cin}))
                else $error("ripple chain sum mismatch");
        end
    end
endmodule

// File: rtl/mxau_top.sv
// Module: selectable-operand arithmetic unit; operand A goes straight to the adder and
// the second operand comes from a per-bit selector (B, ~B, zeros, ones).
// Assumes: purely combinational use; the carry input supplies the +1 of each operation.
module mxau_top
    import mxau_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [1:0]       sel_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] d_o,
    output logic             cout_o
);
    localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

    opnd_sel_e        sel_q;
    logic [WIDTH-1:0] y_opnd;

    // Interpret the raw select lines as the shared operand code.
    always_comb sel_q = opnd_sel_e'(sel_i);

    mxau_operand_mux #(.WIDTH(WIDTH)) u_mux (
        .opnd_b (b_i),
        .sel    (sel_q),
        .y      (y_opnd)
    );

    mxau_ripple_chain #(.WIDTH(WIDTH)) u_chain (
        .x    (a_i),
        .y    (y_opnd),
        .cin  (cin_i),
        .sum  (d_o),
        .cout (cout_o)
    );

    // Check each operation at the ports against its arithmetic meaning.
    always_comb begin
        if (!$isunknown({a_i, b_i, sel_i, cin_i})) begin
            if (sel_i == 2'b00)
                assert_add_R2: assert ({cout_o, d_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i}))
                    else $error("add result mismatch");
            if (sel_i == 2'b01 && cin_i)
                assert_sub_R3: assert (d_o == a_i - b_i && cout_o == (a_i >= b_i))
                    else $error("subtract result mismatch");
            if (sel_i == 2'b10)
                assert_incr_R4: assert (d_o == a_i + {{(WIDTH-1){1'b0}}, cin_i} && cout_o == (cin_i && a_i == ALL_ONES))
                    else $error("transfer/increment mismatch");
            if (sel_i == 2'b11 && !cin_i)
                assert_decr_R5: assert (d_o == a_i - 1'b1 && cout_o == (a_i != '0))
                    else $error("decrement mismatch");
            if (sel_i == 2'b11 && cin_i)
                assert_pass_R5: assert (d_o == a_i && cout_o)
                    else $error("transfer with carry mismatch");
        end
    end
endmodule

// File: tb/mxau_top_tb_top.sv
`timescale 1ns/1ps
module mxau_top_tb_top;
    logic       clk = 1'b0;
    logic [3:0] a, b;
    logic [1:0] sel;
    logic       cin;
    logic [3:0] d;
    logic       cout;
    int         checks = 0;
    int         failures = 0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    mxau_top #(.WIDTH(4)) dut_i (
        .a_i (a), .b_i (b), .sel_i (sel), .cin_i (cin),
        .d_o (d), .cout_o (cout)
    );

    // Expected {cout, d} from the requirement table.
    function automatic logic [4:0] ref_op(logic [3:0] ra, logic [3:0] rb, logic [1:0] rs, logic rc);
        logic [4:0] y;
        case (rs)
            2'b00:   y = {1'b0, rb};
            2'b01:   y = {1'b0, ~rb};
            2'b10:   y = 5'd0;
            default: y = 5'd15;
        endcase
        return {1'b0, ra} + y + {4'd0, rc};
    endfunction

    function automatic string req_of(logic [1:0] rs);
        case (rs)
            2'b00:   return "R2";
            2'b01:   return "R3";
            2'b10:   return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic apply_check(string req, logic [3:0] ta, logic [3:0] tb, logic [1:0] ts,
                               logic tc, logic [4:0] expv);
        a = ta; b = tb; sel = ts; cin = tc;
        #2;
        checks++;
        if ({cout, d} !== expv) begin
            failures++;
            $display("FAIL %s a=%h b=%h sel=%b cin=%b actual=%b_%h expected=%b_%h",
                     req, ta, tb, ts, tc, cout, d, expv[4], expv[3:0]);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Idle state: all-zero inputs give zero result and no carry (R1).
        apply_check("R1", 4'h0, 4'h0, 2'b00, 1'b0, 5'h00);
        // Exhaustive sweep of every operation code and operand pair (R1..R5).
        for (int s = 0; s < 4; s++)
            for (int c = 0; c < 2; c++)
                for (int x = 0; x < 16; x++)
                    for (int z = 0; z < 16; z++)
                        apply_check(req_of(2'(s)), 4'(x), 4'(z), 2'(s), 1'(c),
                                    ref_op(4'(x), 4'(z), 2'(s), 1'(c)));
        // Directed corners.
        apply_check("R4", 4'hF, 4'h3, 2'b10, 1'b1, 5'h10); // increment wraps, carry out
        apply_check("R4", 4'h9, 4'h3, 2'b10, 1'b0, 5'h09); // plain transfer
        apply_check("R5", 4'h0, 4'h7, 2'b11, 1'b0, 5'h0F); // decrement of zero, no carry
        apply_check("R5", 4'h1, 4'h7, 2'b11, 1'b0, 5'h10); // decrement to zero, carry
        apply_check("R5", 4'h6, 4'h2, 2'b11, 1'b1, 5'h16); // transfer with carry set
        apply_check("R3", 4'h5, 4'h5, 2'b01, 1'b1, 5'h10); // A-B equal, no borrow
        apply_check("R3", 4'h4, 4'h5, 2'b01, 1'b1, 5'h0F); // A<B, borrow
        apply_check("R3", 4'h4, 4'h5, 2'b01, 1'b0, 5'h0E); // A+~B
        apply_check("R6", 4'hF, 4'h0, 2'b00, 1'b1, 5'h10); // full ripple
        apply_check("R6", 4'h8, 4'h8, 2'b00, 1'b0, 5'h10); // MSB carry only
        apply_check("R2", 4'h7, 4'h8, 2'b00, 1'b1, 5'h10); // add with carry
        // Seeded random order: outputs track each new input with no clock (R7).
        for (int k = 0; k < 400; k++) begin
            logic [3:0] ra = 4'($urandom);
            logic [3:0] rb = 4'($urandom);
            logic [1:0] rs = 2'($urandom);
            logic       rc = 1'($urandom);
            apply_check("R7", ra, rb, rs, rc, ref_op(ra, rb, rs, rc));
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule